// File: doc/BRIEF.md
# Sequential Array Maximum-Index Finder

This block keeps a small register array of unsigned entries and, when asked, finds the position of the largest one. Software or a neighbouring unit fills the array through a plain write port (address, data, enable). A single-cycle `start` pulse then launches a search. The search reads one entry per clock, compares it against the best value seen so far, and ends with a one-cycle `done` pulse. The winning index stays on `best_idx` until the next search begins.

The search seeds entry 0 as the best candidate and scans upward from entry 1. A candidate replaces the best only when its value is strictly larger, so the lowest position wins among equal values. While a search runs, the block ignores both `start` and the write port. With the default four entries, a search always takes the same fixed number of cycles.

Top module: `argmax_scan`

## Requirements
- R1: While `rst_n` is low, and after it is released, `done` reads 0 and `best_idx` reads 0 until a search is accepted.
- R2: At `done`, `best_idx` equals the index i whose value is strictly larger than every entry below it and not smaller than any entry above it. Values are unsigned 8-bit, with 4 entries and a 2-bit index.
- R3: If `start` is sampled high at a clock edge in the idle state, `done` is high exactly between the 6th and the 7th rising edge after that edge, and low at all other times.
- R4: After `done`, `best_idx` holds its value until the next accepted `start`.
- R5: A `start` pulse that arrives while a search is running, including the `done` cycle, is ignored. It neither shifts the pending `done` nor causes a second one.
- R6: A write that arrives while a search is running changes neither the current result nor the array contents seen by later searches.
- R7: `start` needs to be high for only one cycle. In the cycle after an accepted `start`, `best_idx` reads 0.
- R8: In the idle state, a write with `wr_en` high stores `wr_data` into the entry selected by `wr_addr` (0 to 3).

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock, rising edge |
| rst_n | input | 1 | Asynchronous active-low reset, released synchronously inside |
| wr_en | input | 1 | Array write enable, honoured only while idle |
| wr_addr | input | 2 | Entry to write |
| wr_data | input | 8 | Value to write |
| start | input | 1 | One-cycle pulse that begins a search |
| done | output | 1 | One-cycle pulse when the result is ready |
| best_idx | output | 2 | Registered index of the largest entry |

## Verification
A broken comparison or a bad best-value register shows at the ports as a wrong `best_idx` at the very `done` pulse of the search it affects. The exhaustive value sweep, which includes ties and extreme values, exposes it within one search. A faulty scan counter or state sequence moves or duplicates the `done` pulse, and the bench catches this in the same search because it checks `done` on every cycle around its expected position. A leaky write or start gate shows as a changed result, either in the disturbed search or in the undisturbed search that follows it.

// File: rtl/argmax_pkg.sv
package argmax_pkg;
  typedef enum logic [2:0] {
    ST_IDLE = 3'd0,
    ST_CMP  = 3'd1,
    ST_TAKE = 3'd2,
    ST_KEEP = 3'd3,
    ST_FIN  = 3'd4
  } scan_state_t;
endpackage

// File: rtl/argmax_regfile.sv
module argmax_regfile #(
  parameter int ENTRIES = 4,
  parameter int DATA_W  = 8,
  localparam int IDX_W  = $clog2(ENTRIES)
) (
  input  logic              clk,
  input  logic              we,
  input  logic [IDX_W-1:0]  waddr,
  input  logic [DATA_W-1:0] wdata,
  input  logic [IDX_W-1:0]  raddr,
  output logic [DATA_W-1:0] rdata
);
  logic [ENTRIES-1:0][DATA_W-1:0] cells;

  for (genvar e = 0; e < ENTRIES; e++) begin : g_cell
    logic              sel;
    logic [DATA_W-1:0] q;
    assign sel = we && (waddr == IDX_W'(e));
    always_ff @(posedge clk) begin
      if (sel) q <= wdata;
    end
    assign cells[e] = q;
  end

  assign rdata = cells[raddr];
endmodule

// File: rtl/argmax_ctrl.sv
module argmax_ctrl
  import argmax_pkg::*;
(
  input  logic        clk,
  input  logic        rst_n,
  input  logic        start,
  input  logic        cand_gt,
  input  logic        scan_last,
  output scan_state_t state,
  output logic        idle,
  output logic        seed_ld,
  output logic        take_ld,
  output logic        scan_step,
  output logic        fin
);
  scan_state_t state_q, state_d;

  always_comb begin
    state_d = state_q;
    case (state_q)
      ST_IDLE: if (start) state_d = ST_CMP;
      ST_CMP:  state_d = cand_gt ? ST_TAKE : ST_KEEP;
      ST_TAKE: state_d = scan_last ? ST_FIN : ST_CMP;
      ST_KEEP: state_d = scan_last ? ST_FIN : ST_CMP;
      ST_FIN:  state_d = ST_IDLE;
      default: state_d = ST_IDLE;
    endcase
  end

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) state_q <= ST_IDLE;
    else        state_q <= state_d;
  end

  assign state     = state_q;
  assign idle      = (state_q == ST_IDLE);
  assign seed_ld   = idle && start;
  assign take_ld   = (state_q == ST_TAKE);
  assign scan_step = ((state_q == ST_TAKE) || (state_q == ST_KEEP)) && !scan_last;
  assign fin       = (state_q == ST_FIN);
endmodule

// File: rtl/argmax_dpath.sv
module argmax_dpath #(
  parameter int ENTRIES = 4,
  parameter int DATA_W  = 8,
  localparam int IDX_W  = $clog2(ENTRIES)
) (
  input  logic              clk,
  input  logic              rst_n,
  input  logic              idle,
  input  logic              seed_ld,
  input  logic              take_ld,
  input  logic              scan_step,
  input  logic [DATA_W-1:0] rdata,
  output logic [IDX_W-1:0]  raddr,
  output logic [IDX_W-1:0]  scan_idx,
  output logic [IDX_W-1:0]  best_idx,
  output logic              cand_gt,
  output logic              scan_last
);
  localparam logic [IDX_W-1:0] LAST_IDX = IDX_W'(ENTRIES - 1);

  logic [IDX_W-1:0]  scan_q, scan_d;
  logic [IDX_W-1:0]  bidx_q, bidx_d;
  logic [DATA_W-1:0] bval_q, bval_d;
  logic              scan_en, best_en;

  assign raddr     = idle ? '0 : scan_q;
  assign cand_gt   = rdata > bval_q;
  assign scan_last = (scan_q == LAST_IDX);

  assign scan_en = seed_ld || scan_step;
  assign best_en = seed_ld || take_ld;

  always_comb begin
    scan_d = seed_ld ? IDX_W'(1) : scan_q + IDX_W'(1);
    bidx_d = seed_ld ? '0 : scan_q;
    bval_d = rdata;
  end

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) begin
      scan_q <= '0;
      bidx_q <= '0;
      bval_q <= '0;
    end else begin
      if (scan_en) scan_q <= scan_d;
      if (best_en) begin
        bidx_q <= bidx_d;
        bval_q <= bval_d;
      end
    end
  end

  assign scan_idx = scan_q;
  assign best_idx = bidx_q;
endmodule

// File: rtl/argmax_scan.sv
module argmax_scan
  import argmax_pkg::*;
#(
  parameter int ENTRIES = 4,
  parameter int DATA_W  = 8,
  localparam int IDX_W  = $clog2(ENTRIES)
) (
  input  logic              clk,
  input  logic              rst_n,
  input  logic              wr_en,
  input  logic [IDX_W-1:0]  wr_addr,
  input  logic [DATA_W-1:0] wr_data,
  input  logic              start,
  output logic              done,
  output logic [IDX_W-1:0]  best_idx
);
  logic [1:0]        rst_pipe;
  logic              rst_sync_n;
  scan_state_t       state;
  logic              idle, seed_ld, take_ld, scan_step, cand_gt, scan_last;
  logic              arr_we;
  logic [IDX_W-1:0]  raddr, scan_idx;
  logic [DATA_W-1:0] rdata;

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) rst_pipe <= 2'b00;
    else        rst_pipe <= {rst_pipe[0], 1'b1};
  end
  assign rst_sync_n = rst_pipe[1];

  assign arr_we = wr_en && idle;

  argmax_regfile #(.ENTRIES(ENTRIES), .DATA_W(DATA_W)) u_regfile (
    .clk   (clk),
    .we    (arr_we),
    .waddr (wr_addr),
    .wdata (wr_data),
    .raddr (raddr),
    .rdata (rdata)
  );

  argmax_ctrl u_ctrl (
    .clk       (clk),
    .rst_n     (rst_sync_n),
    .start     (start),
    .cand_gt   (cand_gt),
    .scan_last (scan_last),
    .state     (state),
    .idle      (idle),
    .seed_ld   (seed_ld),
    .take_ld   (take_ld),
    .scan_step (scan_step),
    .fin       (done)
  );

  argmax_dpath #(.ENTRIES(ENTRIES), .DATA_W(DATA_W)) u_dpath (
    .clk       (clk),
    .rst_n     (rst_sync_n),
    .idle      (idle),
    .seed_ld   (seed_ld),
    .take_ld   (take_ld),
    .scan_step (scan_step),
    .rdata     (rdata),
    .raddr     (raddr),
    .scan_idx  (scan_idx),
    .best_idx  (best_idx),
    .cand_gt   (cand_gt),
    .scan_last (scan_last)
  );
endmodule

// File: rtl/argmax_scan_chk.sv
module argmax_scan_chk
  import argmax_pkg::*;
#(
  parameter int IDX_W = 2
) (
  input logic             clk,
  input logic             rst_sync_n,
  input scan_state_t      state,
  input logic             start,
  input logic             arr_we,
  input logic             done,
  input logic [IDX_W-1:0] scan_idx,
  input logic [IDX_W-1:0] best_idx
);
  // R3: completion flag never lasts two cycles
  assert_done_single_R3: assert property (@(posedge clk) disable iff (!rst_sync_n)
    done |=> !done);

  // R4: result register frozen across the end of a search
  assert_idx_hold_R4: assert property (@(posedge clk) disable iff (!rst_sync_n)
    done |=> $stable(best_idx));

  // R7: an accepted start seeds index 0 and enters the compare phase
  assert_seed_R7: assert property (@(posedge clk) disable iff (!rst_sync_n)
    (state == ST_IDLE && start) |=> (state == ST_CMP && best_idx == '0));

  // R5: start during a compare does not restart the scan
  assert_busy_start_R5: assert property (@(posedge clk) disable iff (!rst_sync_n)
    (state == ST_CMP && start) |=> (state == ST_TAKE || state == ST_KEEP));

  // R2: compares never target entry 0, which seeds the search
  assert_scan_nonzero_R2: assert property (@(posedge clk) disable iff (!rst_sync_n)
    (state == ST_CMP) |-> (scan_idx != '0));

  // R6: the array is never written outside the idle state
  assert_write_gate_R6: assert property (@(posedge clk) disable iff (!rst_sync_n)
    arr_we |-> (state == ST_IDLE));
endmodule

bind argmax_scan argmax_scan_chk #(.IDX_W(IDX_W)) u_chk (
  .clk        (clk),
  .rst_sync_n (rst_sync_n),
  .state      (state),
  .start      (start),
  .arr_we     (arr_we),
  .done       (done),
  .scan_idx   (scan_idx),
  .best_idx   (best_idx)
);

// File: tb/argmax_scan_bench.sv
`timescale 1ns/1ps
module argmax_scan_bench;
  logic       clk = 1'b0;
  logic       rst_n;
  logic       wr_en;
  logic [1:0] wr_addr;
  logic [7:0] wr_data;
  logic       start;
  logic       done;
  logic [1:0] best_idx;

  int n_cmp = 0;
  int n_bad = 0;

  always #2 clk = ~clk;

  argmax_scan u_argmax_scan (
    .clk(clk), .rst_n(rst_n), .wr_en(wr_en), .wr_addr(wr_addr),
    .wr_data(wr_data), .start(start), .done(done), .best_idx(best_idx)
  );

  task automatic chk(input string req, input int act, input int exp);
    n_cmp++;
    if (act != exp) begin
      n_bad++;
      $display("FAIL %s: actual %0d expected %0d at %0t", req, act, exp, $time);
    end
  endtask

  task automatic wr(input logic [1:0] a, input logic [7:0] d);
    @(negedge clk);
    wr_en = 1'b1; wr_addr = a; wr_data = d;
    @(negedge clk);
    wr_en = 1'b0;
  endtask

  function automatic int ref_max(input logic [7:0] v [4]);
    int b = 0;
    for (int i = 1; i < 4; i++) if (v[i] > v[b]) b = i;
    return b;
  endfunction

  // Launch a search; optionally disturb it with start and/or a write in its
  // third cycle. exp is the expected index at done.
  task automatic search(input int exp, input bit poke_start, input bit poke_wr,
                        input logic [1:0] pa, input logic [7:0] pd);
    @(negedge clk);
    start = 1'b1;
    @(posedge clk); #1;
    start = 1'b0;
    chk("R7 seed index", best_idx, 0);
    for (int k = 1; k <= 10; k++) begin
      @(posedge clk); #1;
      if (k == 2) begin
        if (poke_start) start = 1'b1;
        if (poke_wr) begin wr_en = 1'b1; wr_addr = pa; wr_data = pd; end
      end
      if (k == 3 || k == 7) begin start = 1'b0; wr_en = 1'b0; end
      if (k == 6 && poke_start) start = 1'b1;  // start during the done cycle
      chk((poke_start ? "R5 done timing" : "R3 done timing"), done, (k == 6) ? 1 : 0);
      if (k == 6) chk("R2 result", best_idx, exp);
      if (k == 10) chk("R4 result held", best_idx, exp);
    end
  endtask

  initial begin
    #(4 * 150000);
    n_bad++;
    $display("FAIL watchdog: actual timeout expected completion");
    $display("*** SUMMARY: %0d compared / %0d mismatched ***", n_cmp, n_bad);
    $finish;
  end

  initial begin
    logic [7:0] pool [4];
    logic [7:0] v [4];
    rst_n = 1'b0; wr_en = 1'b0; wr_addr = '0; wr_data = '0; start = 1'b0;
    pool[0] = 8'd0; pool[1] = 8'd1; pool[2] = 8'd128; pool[3] = 8'd255;
    repeat (3) @(posedge clk);
    #1;
    chk("R1 reset done", done, 0);
    chk("R1 reset index", best_idx, 0);
    @(negedge clk); rst_n = 1'b1;
    repeat (4) @(posedge clk);
    #1;
    chk("R1 released done", done, 0);
    chk("R1 released index", best_idx, 0);

    // R8 / R2: exhaustive sweep over four values per entry, ties included
    for (int c = 0; c < 256; c++) begin
      for (int e = 0; e < 4; e++) begin
        v[e] = pool[(c >> (2 * e)) & 3];
        wr(2'(e), v[e]);
      end
      search(ref_max(v), 1'b0, 1'b0, 2'd0, 8'd0);
    end

    // R5: spurious starts mid-search and in the done cycle
    wr(2'd0, 8'd10); wr(2'd1, 8'd20); wr(2'd2, 8'd40); wr(2'd3, 8'd30);
    search(2, 1'b1, 1'b0, 2'd0, 8'd0);
    // R6: write during a search must not land
    search(2, 1'b0, 1'b1, 2'd0, 8'd250);
    search(2, 1'b0, 1'b0, 2'd0, 8'd0);
    // R8: the same write while idle does land
    wr(2'd0, 8'd250);
    search(0, 1'b0, 1'b0, 2'd0, 8'd0);

    // R1: reset in the middle of a search
    @(negedge clk); start = 1'b1;
    @(negedge clk); start = 1'b0;
    rst_n = 1'b0;
    #1;
    chk("R1 mid-search reset done", done, 0);
    chk("R1 mid-search reset index", best_idx, 0);
    @(negedge clk); rst_n = 1'b1;
    repeat (10) begin
      @(posedge clk); #1;
      chk("R1 no done after reset", done, 0);
    end

    $display("*** SUMMARY: %0d compared / %0d mismatched ***", n_cmp, n_bad);
    $finish;
  end
endmodule